// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block runs the timing of a successive-approximation analog-to-digital converter. Software programs a control/status register and a channel register through a small register port. The block divides the system clock down to a conversion clock and counts conversion-clock periods. At the right periods it emits a sample strobe, a trial code for the external DAC and a done strobe. It resolves a 10-bit result one bit per conversion clock, MSB first, from a single comparator bit.

Each conversion can be started by its own write, or one write can start a free-running series. The first conversion after enabling spends extra periods on initialization. A channel written during a conversion is held pending and takes effect once that conversion ends. Clearing the enable bit stops a conversion immediately and raises no flag. The flag and its enable produce an interrupt request.

Top module: `sarSeqTop`

## Requirements
- R1: After reset, the control/status register (address 0) and the channel register (address 1) read as 0x00. `chanSel` is 0 and `irq` is 0.
- R2: A normal conversion lasts 13 conversion-clock periods. The start bit (address 0, bit 6) reads 0 again exactly 13×N system clocks after the starting write, where N is the divide ratio.
- R3: The first conversion after enable rises lasts 25 periods. This includes a start written in the same write that sets enable (bit 7), and the first start after a disable/re-enable.
- R4: The start bit reads 1 while a conversion runs. Writing 0 to it while busy does not stop or shorten the conversion.
- R5: Writing enable = 0 during a conversion clears busy on the next clock. No done strobe follows, the flag (bit 4) is not set, and the result is unchanged.
- R6: With auto-trigger (bit 5) clear, a conversion runs once per start write. Afterwards the block stays idle with no further done strobe.
- R7: With auto-trigger set, one start write begins back-to-back conversions. Each one after the first lasts 13 periods. Clearing auto-trigger lets the running conversion finish and then stops.
- R8: A channel value written while busy leaves `chanSel` unchanged. It is applied when that conversion completes, so the next conversion uses it.
- R9: Prescaler bits [2:0] select a divide ratio of 2, 2, 4, 8, 16, 32, 64 or 128 for codes 0 to 7.
- R10: The flag is set on completion. Writing 1 to bit 4 clears it and writing 0 leaves it set. `irq` equals flag AND interrupt enable (bit 3).
- R11: The sample strobe falls on conversion-clock period 2 of a normal conversion (14 of the first). The result is resolved MSB first with trial codes on `dacCode`. It equals the comparator-determined input code, and it is loaded with the done strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 1 | 0 = control/status, 1 = channel |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data for `regAddr` |
| cmpIn | input | 1 | Comparator: input >= `dacCode` |
| dacCode | output | 10 | Trial code for the DAC |
| chanSel | output | 4 | Active channel select for the analog multiplexer |
| sampleStrobe | output | 1 | One-cycle pulse at the sample instant |
| doneStrobe | output | 1 | One-cycle pulse at conversion completion |
| resultData | output | 10 | Last completed conversion result |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach from the ports is a channel write that lands inside a free-running series. The write must be held back while the old channel finishes its conversion, then be applied on the exact done edge. The bench starts a free-running series and waits for completions on the done strobe. It writes a new channel in the middle of one conversion. It then checks that this conversion and the next follow the comparator stub of the old and the new channel in turn. The abort path is reached by disabling partway through a slow-prescaler conversion. A re-enable afterwards must bring back the long first conversion.

// File: rtl/sarSeqPkg.sv
package sarSeqPkg;
  localparam int RES_W = 10;
  localparam int IDX_W = $clog2(RES_W);

  typedef struct packed {
    logic             clearSar;
    logic             resolve;
    logic             trialOn;
    logic [IDX_W-1:0] bitIdx;
    logic             loadResult;
  } seqStrobe_t;

  function automatic int unsigned divRatio(input logic [2:0] code);
    return (code == 3'd0) ? 2 : (1 << code);
  endfunction
endpackage

// File: rtl/sarSeqPrescale.sv
module sarSeqPrescale #(
  parameter int DIV_W = 7
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       run,
  input  logic [2:0] psCode,
  output logic       tick
);
  import sarSeqPkg::*;

  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] divLimit;

  assign divLimit = DIV_W'(divRatio(psCode) - 1);
  assign tick     = run && (divCnt >= divLimit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          divCnt <= '0;
    else if (!run)      divCnt <= '0;
    else if (tick)      divCnt <= '0;
    else                divCnt <= divCnt + 1'b1;
  end

  // R9: every ratio is at least two, so ticks never touch
  p_tick_gap_r9: assert property (@(posedge clk) disable iff (!rstN)
    tick |=> !tick);
endmodule

// File: rtl/sarSeqCtrl.sv
module sarSeqCtrl #(
  parameter int NORM_CYC = 13,
  parameter int INIT_CYC = 25,
  parameter int CHAN_W   = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    wrEn,
  input  logic                    wrAddr,
  input  logic [7:0]              wrData,
  output logic [7:0]              rdData,
  input  logic                    tick,
  output logic                    divRun,
  output logic [2:0]              psCode,
  output logic [CHAN_W-1:0]       chanSel,
  output logic                    irq,
  output logic                    sampleStrobe,
  output logic                    doneStrobe,
  output sarSeqPkg::seqStrobe_t   strobe
);
  import sarSeqPkg::*;

  localparam int CYC_W = $clog2(INIT_CYC + 1);
  localparam logic [CYC_W-1:0] NORM_SAMP = CYC_W'(NORM_CYC - RES_W - 2);
  localparam logic [CYC_W-1:0] NORM_BIT0 = CYC_W'(NORM_CYC - RES_W - 1);
  localparam logic [CYC_W-1:0] NORM_BITN = CYC_W'(NORM_CYC - 2);
  localparam logic [CYC_W-1:0] NORM_LAST = CYC_W'(NORM_CYC - 1);
  localparam logic [CYC_W-1:0] INIT_SAMP = CYC_W'(INIT_CYC - RES_W - 2);
  localparam logic [CYC_W-1:0] INIT_BIT0 = CYC_W'(INIT_CYC - RES_W - 1);
  localparam logic [CYC_W-1:0] INIT_BITN = CYC_W'(INIT_CYC - 2);
  localparam logic [CYC_W-1:0] INIT_LAST = CYC_W'(INIT_CYC - 1);

  // register fields
  logic             enReg, autoReg, flagReg, ieReg;
  logic [2:0]       psReg;
  logic             busyReg, firstPend;
  logic [CHAN_W-1:0] chanReg, activeChan;
  logic [CYC_W-1:0] cycCnt;

  // decode
  logic ctrlWr, chanWr, enRise, startReq, abortReq;
  logic [CYC_W-1:0] sampAt, bit0At, bitNAt, lastAt;
  logic inBits, liveTick, doneTick, sampTick;

  assign ctrlWr   = wrEn && (wrAddr == 1'b0);
  assign chanWr   = wrEn && (wrAddr == 1'b1);
  assign enRise   = ctrlWr && wrData[7] && !enReg;
  assign startReq = ctrlWr && wrData[7] && wrData[6] && !busyReg;
  assign abortReq = ctrlWr && !wrData[7] && busyReg;

  assign sampAt = firstPend ? INIT_SAMP : NORM_SAMP;
  assign bit0At = firstPend ? INIT_BIT0 : NORM_BIT0;
  assign bitNAt = firstPend ? INIT_BITN : NORM_BITN;
  assign lastAt = firstPend ? INIT_LAST : NORM_LAST;

  assign liveTick = busyReg && tick && !abortReq;
  assign inBits   = (cycCnt >= bit0At) && (cycCnt <= bitNAt);
  assign sampTick = liveTick && (cycCnt == sampAt);
  assign doneTick = liveTick && (cycCnt == lastAt);

  // strobes toward the datapath
  always_comb begin
    strobe.clearSar   = sampTick;
    strobe.resolve    = liveTick && inBits;
    strobe.trialOn    = busyReg && inBits;
    strobe.bitIdx     = IDX_W'(bitNAt - cycCnt);
    strobe.loadResult = doneTick;
  end

  assign sampleStrobe = sampTick;
  assign doneStrobe   = doneTick;
  assign divRun       = busyReg;
  assign psCode       = psReg;
  assign chanSel      = activeChan;
  assign irq          = flagReg && ieReg;

  always_comb begin
    if (wrAddr == 1'b0) rdData = {enReg, busyReg, autoReg, flagReg, ieReg, psReg};
    else                rdData = 8'(chanReg);
  end

  // control/status fields
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg   <= 1'b0;
      autoReg <= 1'b0;
      ieReg   <= 1'b0;
      psReg   <= 3'd0;
    end else if (ctrlWr) begin
      enReg   <= wrData[7];
      autoReg <= wrData[5];
      ieReg   <= wrData[3];
      psReg   <= wrData[2:0];
    end
  end

  // flag: completion wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                       flagReg <= 1'b0;
    else if (doneTick)               flagReg <= 1'b1;
    else if (ctrlWr && wrData[4])    flagReg <= 1'b0;
  end

  // long first conversion marker
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         firstPend <= 1'b0;
    else if (enRise)   firstPend <= 1'b1;
    else if (doneTick) firstPend <= 1'b0;
  end

  // busy and period counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyReg <= 1'b0;
      cycCnt  <= '0;
    end else begin
      if (abortReq)      busyReg <= 1'b0;
      else if (startReq) busyReg <= 1'b1;
      else if (doneTick) busyReg <= autoReg && enReg;

      if (!busyReg || doneTick || abortReq) cycCnt <= '0;
      else if (tick)                        cycCnt <= cycCnt + 1'b1;
    end
  end

  // channel: written value held, applied when idle or on completion
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chanReg    <= '0;
      activeChan <= '0;
    end else begin
      if (chanWr) chanReg <= wrData[CHAN_W-1:0];
      if (!busyReg || doneTick) activeChan <= chanReg;
    end
  end

  // R8: active channel frozen inside a conversion
  p_chan_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busyReg && !doneTick) |=> $stable(chanSel));
  // R10: completion always leaves the flag set
  p_done_flag_r10: assert property (@(posedge clk) disable iff (!rstN)
    doneTick |=> (rdData[4] || wrAddr));
  // R5: disabling ends the conversion on the next clock
  p_abort_idle_r5: assert property (@(posedge clk) disable iff (!rstN)
    abortReq |=> !busyReg);
  // R4: an accepted start makes the block busy
  p_start_busy_r4: assert property (@(posedge clk) disable iff (!rstN)
    startReq |=> busyReg);
  // R6: single mode drops busy after completion
  p_single_stop_r6: assert property (@(posedge clk) disable iff (!rstN)
    (doneTick && !autoReg) |=> !busyReg);
  // R11: sampling never coincides with a bit decision
  p_samp_not_bit_r11: assert property (@(posedge clk) disable iff (!rstN)
    sampTick |-> !strobe.resolve);
endmodule

// File: rtl/sarSeqData.sv
module sarSeqData (
  input  logic                          clk,
  input  logic                          rstN,
  input  sarSeqPkg::seqStrobe_t         strobe,
  input  logic                          cmpIn,
  output logic [sarSeqPkg::RES_W-1:0]   dacCode,
  output logic [sarSeqPkg::RES_W-1:0]   resultData
);
  import sarSeqPkg::*;

  logic [RES_W-1:0] sarReg;
  logic [RES_W-1:0] trialBit;

  assign trialBit = RES_W'(1) << strobe.bitIdx;
  assign dacCode  = strobe.trialOn ? (sarReg | trialBit) : sarReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sarReg     <= '0;
      resultData <= '0;
    end else begin
      if (strobe.clearSar)     sarReg <= '0;
      else if (strobe.resolve) sarReg[strobe.bitIdx] <= cmpIn;
      if (strobe.loadResult)   resultData <= sarReg;
    end
  end

  // R11: at most one datapath action per clock
  p_strobe_excl_r11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.clearSar, strobe.resolve, strobe.loadResult}));
  // R11: decisions address a real result bit
  p_bit_range_r11: assert property (@(posedge clk) disable iff (!rstN)
    strobe.resolve |-> (int'(strobe.bitIdx) < RES_W));
endmodule

// File: rtl/sarSeqTop.sv
module sarSeqTop #(
  parameter int NORM_CYC = 13,
  parameter int INIT_CYC = 25,
  parameter int CHAN_W   = 4,
  parameter int DIV_W    = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regAddr,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData,
  input  logic              cmpIn,
  output logic [9:0]        dacCode,
  output logic [CHAN_W-1:0] chanSel,
  output logic              sampleStrobe,
  output logic              doneStrobe,
  output logic [9:0]        resultData,
  output logic              irq
);
  import sarSeqPkg::*;

  seqStrobe_t strobe;
  logic       tick, divRun;
  logic [2:0] psCode;

  sarSeqPrescale #(.DIV_W(DIV_W)) uPrescale (
    .clk(clk), .rstN(rstN), .run(divRun), .psCode(psCode), .tick(tick)
  );

  sarSeqCtrl #(.NORM_CYC(NORM_CYC), .INIT_CYC(INIT_CYC), .CHAN_W(CHAN_W)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(regWrEn), .wrAddr(regAddr), .wrData(regWrData),
    .rdData(regRdData), .tick(tick), .divRun(divRun), .psCode(psCode),
    .chanSel(chanSel), .irq(irq), .sampleStrobe(sampleStrobe),
    .doneStrobe(doneStrobe), .strobe(strobe)
  );

  sarSeqData uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cmpIn(cmpIn),
    .dacCode(dacCode), .resultData(resultData)
  );
endmodule

// File: tb/tb_sarSeqTop.sv
`timescale 1ns/1ps
module tb_sarSeqTop;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic       regAddr = 1'b0;
  logic [7:0] regWrData = 8'h00;
  logic [7:0] regRdData;
  logic       cmpIn;
  logic [9:0] dacCode;
  logic [3:0] chanSel;
  logic       sampleStrobe, doneStrobe, irq;
  logic [9:0] resultData;

  int errors = 0;
  int checks = 0;
  bit finished = 0;
  logic [9:0] analog [16];

  always #10 clk = ~clk;

  // comparator stub: true when the channel input is at or above the trial
  assign cmpIn = (analog[chanSel] >= dacCode);

  sarSeqTop dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .cmpIn(cmpIn),
    .dacCode(dacCode), .chanSel(chanSel), .sampleStrobe(sampleStrobe),
    .doneStrobe(doneStrobe), .resultData(resultData), .irq(irq)
  );

  function automatic int benchRatio(input int ps);
    return (ps == 0) ? 2 : (1 << ps);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(posedge clk); #1;
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    regAddr = a; #1;
    d = regRdData;
  endtask

  // counts edges after the starting write until busy reads 0
  task automatic measure(output int sampN, output int doneN, output int endN);
    sampN = -1; doneN = -1; endN = -1;
    regAddr = 1'b0;
    for (int n = 1; n < 20000; n++) begin
      @(posedge clk); #1;
      if (sampleStrobe && sampN < 0) sampN = n;
      if (doneStrobe) doneN = n;
      if (!regRdData[6]) begin endN = n; break; end
    end
  endtask

  task automatic waitDone(output int n);
    n = -1;
    for (int k = 1; k < 20000; k++) begin
      @(posedge clk); #1;
      if (doneStrobe) begin n = k; break; end
    end
  endtask

  task automatic quiet(input int cyc, output int seen);
    seen = 0;
    for (int k = 0; k < cyc; k++) begin
      @(posedge clk); #1;
      if (doneStrobe) seen++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog act=1 exp=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [9:0] prevRes;
    int sN, dN, eN, seen, r, ch, ps, ie;
    int chList [10] = '{0, 1, 2, 3, 4, 5, 6, 7, 14, 15};

    void'($urandom(32'h5EED));
    for (int i = 0; i < 16; i++) analog[i] = 10'($urandom);
    analog[7]  = 10'd1023;
    analog[0]  = 10'd0;
    analog[14] = 10'd450;
    analog[15] = 10'd0;

    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(1'b0, d); chk(d == 8'h00, "R1 ctrl reset", d, 0);
    rd(1'b1, d); chk(d == 8'h00, "R1 chan reset", d, 0);
    chk(irq == 1'b0, "R1 irq reset", irq, 0);
    chk(chanSel == 4'd0, "R1 chanSel reset", chanSel, 0);

    // R3 enable and start in one write, ratio 2
    wr(1'b1, 8'd3);
    wr(1'b0, 8'hC1);
    measure(sN, dN, eN);
    chk(eN == 50, "R3 first conversion length", eN, 50);
    chk(sN == 27, "R11 first sample instant", sN, 27);
    chk(dN == 49, "R11 done strobe instant", dN, 49);
    chk(resultData == analog[3], "R11 result ch3", resultData, analog[3]);
    rd(1'b0, d); chk(d[4] == 1'b1, "R10 flag set", d[4], 1);

    // R10 write 0 keeps flag, irq follows enable, write 1 clears
    wr(1'b0, 8'h81); rd(1'b0, d);
    chk(d[4] == 1'b1, "R10 flag kept on write 0", d[4], 1);
    chk(irq == 1'b0, "R10 irq masked", irq, 0);
    wr(1'b0, 8'h89);
    chk(irq == 1'b1, "R10 irq raised", irq, 1);
    wr(1'b0, 8'h99); rd(1'b0, d);
    chk(d[4] == 1'b0, "R10 flag cleared", d[4], 0);
    chk(irq == 1'b0, "R10 irq cleared", irq, 0);

    // R4 busy readback, writing 0 to start does not stop it
    wr(1'b0, 8'hC9); rd(1'b0, d);
    chk(d[6] == 1'b1, "R4 busy reads one", d[6], 1);
    wr(1'b0, 8'h89);
    measure(sN, dN, eN);
    chk(eN == 25, "R4 zero write ignored, R2 length", eN, 25);
    chk(irq == 1'b1, "R10 irq after completion", irq, 1);
    // R6 single mode stays idle
    quiet(100, seen);
    chk(seen == 0, "R6 no extra conversion", seen, 0);
    rd(1'b0, d); chk(d[6] == 1'b0, "R6 idle", d[6], 0);

    // R2 R9 R11 random conversions
    for (int it = 0; it < 16; it++) begin
      ch = chList[$urandom % 10];
      ps = $urandom % 6;
      ie = $urandom % 2;
      r  = benchRatio(ps);
      wr(1'b1, 8'(ch));
      wr(1'b0, 8'(8'hD0 | (ie << 3) | ps));
      measure(sN, dN, eN);
      chk(eN == 13 * r, "R2 R9 normal length", eN, 13 * r);
      chk(sN == 2 * r - 1, "R11 normal sample instant", sN, 2 * r - 1);
      chk(resultData == analog[ch], "R11 random result", resultData, analog[ch]);
      chk(irq == 1'(ie), "R10 irq vs enable", irq, ie);
      chk(chanSel == 4'(ch), "R8 idle channel applied", chanSel, ch);
    end

    // R9 slowest ratio
    wr(1'b0, 8'hD7);
    measure(sN, dN, eN);
    chk(eN == 13 * 128, "R9 ratio 128", eN, 13 * 128);

    // R5 abort mid-conversion
    prevRes = resultData;
    wr(1'b0, 8'hD2);
    repeat (20) @(posedge clk);
    wr(1'b0, 8'h02);
    rd(1'b0, d);
    chk(d[6] == 1'b0, "R5 busy cleared", d[6], 0);
    chk(d[4] == 1'b0, "R5 no flag", d[4], 0);
    quiet(200, seen);
    chk(seen == 0, "R5 no done strobe", seen, 0);
    chk(resultData == prevRes, "R5 result unchanged", resultData, prevRes);

    // R3 re-enable gives the long conversion again
    wr(1'b0, 8'hC2);
    measure(sN, dN, eN);
    chk(eN == 100, "R3 first after re-enable", eN, 100);

    // R7 R8 free running with a pending channel
    wr(1'b1, 8'd2);
    repeat (2) @(posedge clk);
    wr(1'b0, 8'hF1);
    waitDone(dN);
    chk(dN == 25, "R7 first free-run done", dN, 25);
    @(posedge clk); #1;
    chk(resultData == analog[2], "R7 free-run result 1", resultData, analog[2]);
    waitDone(dN);
    chk(dN == 25, "R7 back-to-back interval", dN, 25);
    @(posedge clk); #1;
    chk(resultData == analog[2], "R7 free-run result 2", resultData, analog[2]);
    wr(1'b1, 8'd6);
    chk(chanSel == 4'd2, "R8 channel held while busy", chanSel, 2);
    waitDone(dN);
    @(posedge clk); #1;
    chk(resultData == analog[2], "R8 old channel finishes", resultData, analog[2]);
    chk(chanSel == 4'd6, "R8 channel applied at done", chanSel, 6);
    waitDone(dN);
    @(posedge clk); #1;
    chk(resultData == analog[6], "R8 new channel used", resultData, analog[6]);
    wr(1'b0, 8'h81);
    waitDone(dN);
    @(posedge clk); #1;
    rd(1'b0, d);
    chk(d[6] == 1'b0, "R7 stops after auto off", d[6], 0);
    quiet(60, seen);
    chk(seen == 0, "R7 no further conversion", seen, 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule